// File: doc/BRIEF.md
# Synchronous Trigger and Timestamp-Reset Emitter

This block drives the trigger side of a device link in which the device runs from a clock supplied by the trigger unit. All inputs are sampled on that interface clock, nominally 40 MHz, and both outputs are registered on it. An accepted trigger request produces a trigger pulse exactly one interface cycle long. A run-start strobe produces a one-cycle timestamp reset on the sync/T0 line. The device can hold BUSY high at any time to refuse triggers.

In the numbered variant, the sync/T0 line has a second job. Right after each trigger pulse it carries the number of that trigger, lowest bit first. The number comes from a run-scoped counter. The counter is cleared by the run-start strobe and advances by one for every trigger issued. A new trigger cannot be issued while a number is still being sent.

Top module: `sync_trig_emitter`

## Requirements
- R1: After reset, `trig_out` and `sync_out` are low and the trigger counter is 0, so the first trigger sent with its number carries 0.
- R2: When a request is accepted at a clock edge, `trig_out` is high for exactly the following cycle. A request is never accepted at the edge that ends a trigger pulse, so two pulses are always separated by at least one low cycle.
- R3: A high `run_start` at an edge makes `sync_out` high for exactly the following cycle.
- R4: A request sampled while `dut_busy` is high is discarded, and `trig_out` stays low in the following cycle.
- R5: With `num_mode` high at acceptance, `sync_out` carries the trigger number on the 32 cycles right after the trigger pulse, bit 0 first and bit 31 last. Bit k is sent in the cycle that follows the edge k+1 edges after the accepting edge.
- R6: If a numbered trigger is accepted at edge k, requests at edges k+1 through k+32 are discarded.
- R7: `run_start` takes priority over a request at the same edge. No trigger is issued, the counter is cleared to 0, and any number still being sent is abandoned.
- R8: `sync_out` is low in every cycle that carries neither a timestamp reset nor a number bit.
- R9: The counter advances by one for each trigger issued in either mode and wraps modulo 2^32. The number sent with a trigger is the counter value before that trigger's increment.
- R10: `num_mode` is sampled only at acceptance. Changing it while a number is being sent does not alter or stop the transmission.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_req | input | 1 | Trigger request from the trigger logic |
| run_start | input | 1 | One-cycle strobe at start of a run |
| dut_busy | input | 1 | Device veto, high = refuse triggers |
| num_mode | input | 1 | 1 = send trigger number after each trigger |
| trig_out | output | 1 | Trigger line to the device |
| sync_out | output | 1 | Sync/T0 line: timestamp reset or number bits |

## Verification
The hardest situation to reach is a run-start strobe that lands partway through a number transmission, at the same edge as a request. The same goes for a request arriving at exactly the last veto edge of a stream. Directed sequences place a strobe in the middle of a stream and step requests edge by edge across the end of the veto window. Long random stretches, with frequent requests and a small run-start probability, reach the remaining mixes of BUSY, mode flips and counter values. A cycle-level model in the bench checks every output cycle.

// File: rtl/trig_emit_pkg.sv
package trig_emit_pkg;

  // A request becomes a trigger only when nothing else claims the edge.
  function automatic logic may_issue(input logic req, input logic busy,
                                     input logic streaming, input logic pulse_now,
                                     input logic run_begin);
    return req & ~busy & ~streaming & ~pulse_now & ~run_begin;
  endfunction

  // Width of a down-counter that must hold the value n.
  function automatic int left_bits(input int n);
    return $clog2(n + 1);
  endfunction

endpackage

// File: rtl/trig_num_counter.sv
module trig_num_counter #(
  parameter int NUM_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             step,
  output logic [NUM_W-1:0] count
);

  always_ff @(posedge clk) begin
    if (!rst_n)      count <= '0;
    else if (clear)  count <= '0;
    else if (step)   count <= count + NUM_W'(1);
  end

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !clear) |=> (count == $past(count) + NUM_W'(1))); // R9
  AST_COUNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (count == '0)); // R7

endmodule

// File: rtl/sync_num_shifter.sv
module sync_num_shifter #(
  parameter int NUM_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             abort,
  input  logic             load,
  input  logic [NUM_W-1:0] value,
  output logic             bit_q,
  output logic             active
);
  import trig_emit_pkg::*;

  localparam int CW = left_bits(NUM_W);

  logic [NUM_W-1:0] sh_q;
  logic [CW-1:0]    left_q;

  assign active = (left_q != '0);

  always_ff @(posedge clk) begin
    if (!rst_n || abort) begin
      sh_q   <= '0;
      left_q <= '0;
      bit_q  <= 1'b0;
    end else if (load) begin
      sh_q   <= value;
      left_q <= CW'(NUM_W);
      bit_q  <= 1'b0;
    end else if (active) begin
      bit_q  <= sh_q[0];
      sh_q   <= sh_q >> 1;
      left_q <= left_q - CW'(1);
    end else begin
      bit_q  <= 1'b0;
    end
  end

  AST_LOAD_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !abort) |=> active); // R5
  AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !load) |=> !bit_q); // R8
  AST_ABORT_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (!active && !bit_q)); // R7

endmodule

// File: rtl/sync_trig_emitter.sv
module sync_trig_emitter #(
  parameter int NUM_W = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig_req,
  input  logic run_start,
  input  logic dut_busy,
  input  logic num_mode,
  output logic trig_out,
  output logic sync_out
);
  import trig_emit_pkg::*;

  logic             trig_q;
  logic             t0_q;
  logic             issue;
  logic             load_num;
  logic             stream_active;
  logic             stream_bit;
  logic [NUM_W-1:0] trig_num;

  assign issue    = may_issue(trig_req, dut_busy, stream_active, trig_q, run_start);
  assign load_num = issue & num_mode;

  trig_num_counter #(.NUM_W(NUM_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (run_start),
    .step  (issue),
    .count (trig_num)
  );

  sync_num_shifter #(.NUM_W(NUM_W)) u_shift (
    .clk    (clk),
    .rst_n  (rst_n),
    .abort  (run_start),
    .load   (load_num),
    .value  (trig_num),
    .bit_q  (stream_bit),
    .active (stream_active)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      trig_q <= 1'b0;
      t0_q   <= 1'b0;
    end else begin
      trig_q <= issue;
      t0_q   <= run_start;
    end
  end

  assign trig_out = trig_q;
  assign sync_out = t0_q | stream_bit;

  AST_TRIG_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    trig_out |=> !trig_out); // R2
  AST_BUSY_VETO: assert property (@(posedge clk) disable iff (!rst_n)
    dut_busy |=> !trig_out); // R4
  AST_RUN_T0: assert property (@(posedge clk) disable iff (!rst_n)
    run_start |=> sync_out); // R3
  AST_RUN_PRIO: assert property (@(posedge clk) disable iff (!rst_n)
    run_start |=> !trig_out); // R7
  AST_STREAM_VETO: assert property (@(posedge clk) disable iff (!rst_n)
    (stream_active && trig_req) |=> !trig_out); // R6
  AST_T0_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (t0_q && !run_start) |=> !t0_q); // R3

endmodule

// File: tb/sim_sync_trig_emitter.sv
module sim_sync_trig_emitter;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic trig_req = 1'b0, run_start = 1'b0, dut_busy = 1'b0, num_mode = 1'b0;
  logic trig_out, sync_out;

  always #2.5 clk = ~clk;

  sync_trig_emitter u0 (
    .clk(clk), .rst_n(rst_n), .trig_req(trig_req), .run_start(run_start),
    .dut_busy(dut_busy), .num_mode(num_mode), .trig_out(trig_out), .sync_out(sync_out)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // bench reference state
  logic [31:0] m_cnt = '0, m_sh = '0;
  int          m_left = 0;
  logic        m_trig = 0, m_sync = 0;
  string       tag_t = "R1", tag_s = "R1";

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
    end
  endtask

  function automatic logic [31:0] next_num(input logic [31:0] v);
    return v + 32'd1;
  endfunction

  task automatic model_edge(input logic r, input logic s, input logic b, input logic m);
    logic was_trig = m_trig;
    int   was_left = m_left;
    if (s) begin
      m_sync = 1; m_trig = 0; m_cnt = '0; m_left = 0; m_sh = '0;
      tag_s = "R3"; tag_t = "R7";
    end else begin
      if (was_left > 0) begin
        m_sync = m_sh[0]; m_sh = m_sh >> 1; m_left--; tag_s = "R5";
      end else begin
        m_sync = 0; tag_s = "R8";
      end
      tag_t = b ? "R4" : (was_left > 0 ? "R6" : "R2");
      if (r && !b && was_left == 0 && !was_trig) begin
        m_trig = 1;
        if (m) begin m_sh = m_cnt; m_left = 32; end
        m_cnt = next_num(m_cnt);
      end else m_trig = 0;
    end
  endtask

  task automatic step(input logic r, input logic s, input logic b, input logic m);
    @(negedge clk);
    trig_req = r; run_start = s; dut_busy = b; num_mode = m;
    @(posedge clk);
    model_edge(r, s, b, m);
    #1;
    check(tag_t, 32'(trig_out), 32'(m_trig));
    check(tag_s, 32'(sync_out), 32'(m_sync));
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin : stim
    logic [31:0] got;
    logic        mm;
    repeat (3) @(posedge clk);
    #1;
    check("R1", 32'(trig_out), 0);
    check("R1", 32'(sync_out), 0);
    @(negedge clk); rst_n = 1'b1;

    // R1: first numbered trigger after reset carries 0
    step(1, 0, 0, 1);
    check("R2", 32'(trig_out), 1);
    got = '0;
    for (int i = 0; i < 32; i++) begin step(1, 0, 0, 1); got[i] = sync_out; end
    check("R1", got, 32'd0);
    step(0, 0, 0, 0);

    // R3 run start, then R9 counter advances in plain mode
    step(0, 1, 0, 0);
    check("R3", 32'(sync_out), 1);
    step(0, 0, 0, 0);
    check("R3", 32'(sync_out), 0);
    for (int k = 0; k < 5; k++) begin step(1, 0, 0, 0); step(0, 0, 0, 0); end
    // R2: back-to-back requests give separated pulses
    step(1, 0, 0, 0); step(1, 0, 0, 0);
    check("R2", 32'(trig_out), 0);
    step(0, 0, 0, 0);
    // R4 busy veto
    step(1, 0, 1, 0);
    check("R4", 32'(trig_out), 0);
    // R5/R9/R10: number 6, mode dropped mid-stream
    step(1, 0, 0, 1);
    got = '0;
    for (int i = 0; i < 32; i++) begin step(i == 31, 0, 0, i < 3); got[i] = sync_out; end
    check("R9", got, 32'd6);
    check("R6", 32'(trig_out), 0);
    step(1, 0, 0, 0);
    check("R6", 32'(trig_out), 1);
    step(0, 0, 0, 0);

    // R7: run start mid-stream with a request at the same edge
    step(1, 0, 0, 1);
    for (int i = 0; i < 10; i++) step(0, 0, 0, 1);
    step(1, 1, 0, 1);
    check("R7", 32'(trig_out), 0);
    for (int i = 0; i < 5; i++) begin
      step(0, 0, 0, 0);
      check("R8", 32'(sync_out), 0);
    end
    step(1, 0, 0, 1);
    got = '0;
    for (int i = 0; i < 32; i++) begin step(0, 0, 0, 0); got[i] = sync_out; end
    check("R7", got, 32'd0);

    // random mix
    void'($urandom(32'd1234));
    mm = 0;
    for (int c = 0; c < 20000; c++) begin
      if ($urandom_range(0, 9) < 3) mm = ~mm;
      step($urandom_range(0, 1), $urandom_range(0, 99) < 2,
           $urandom_range(0, 4) == 0, mm);
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule